// File: doc/BRIEF.md
# Oversampling Serial Receiver with Noise Flag

This block receives asynchronous serial frames on a line that has already been brought into the system clock domain. A one-cycle tick enable arrives sixteen times per bit period, and the receiver looks at the line only on those ticks. Each frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit is judged on three centre samples by majority vote. Any disagreement among those samples, or a start bit that did not begin with a clean high-to-low transition, is recorded as noise.

A start bit whose centre samples are mostly high is treated as a glitch. The frame is dropped and no data is delivered. Any noise seen during that false start is held back internally and is reported together with the next frame that completes. When a frame completes, the received byte, the data-ready flag and the noise flag all update on the same clock edge. Software clears both flags by reading the status word and then the data byte. Only the data-ready level goes to the interrupt controller.

Top module: `os_uart_rx`

## Requirements
- R1: After reset the status word is all zeros, the data byte is zero and `rdy_irq_o` is low.
- R2: A clean frame delivers its eight data bits (first bit received lands in bit 0). The ready flag (status bit 0) rises on the clock edge that consumes tick 10 of the stop bit, and not on an earlier tick. Tick 1 of a frame is the first tick on which the line is seen low.
- R3: A data bit whose ticks 8, 9 and 10 do not all agree takes the majority value and sets the noise flag (status bit 1).
- R4: A sample that differs from the rest of its bit only on ticks outside 8 to 10 sets no noise and leaves the data unchanged.
- R5: The visible noise flag rises only on the edge where a frame completes, and it is never set while the ready flag is clear.
- R6: A start bit whose samples on ticks 8, 9, 10 read 011, 101 or 110 (tick 8 first) discards the frame. Ready stays clear, and the noise flag stays clear in the status word.
- R7: Noise held back from a discarded false start appears in status bit 1 together with the ready flag of the next completed frame.
- R8: A start bit whose centre samples are mostly low but disagree (001, 010, 100) is accepted, and the frame completes with the noise flag set.
- R9: A start that begins while the previous tick already saw the line low (no valid falling edge) is accepted, and the frame completes with the noise flag set.
- R10: Disagreeing centre samples in the stop bit set the noise flag for that frame.
- R11: A data read clears both flags only if a status read came after the previous data read. A data read on its own leaves both flags set.
- R12: `rdy_irq_o` equals the ready flag. The noise flag has no output of its own.
- R13: The data byte changes only on the edge where a frame completes. A false start leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Sample enable, one cycle, sixteen per bit period |
| rx_i | input | 1 | Serial line, already synchronous to clk_i |
| rd_stat_i | input | 1 | Status read strobe |
| rd_data_i | input | 1 | Data read strobe |
| status_o | output | 8 | Status word: bit 0 ready, bit 1 noise, other bits zero |
| data_o | output | 8 | Last received byte |
| rdy_irq_o | output | 1 | Data-ready level for the interrupt controller |

## Verification
The bench sends every byte value cleanly and checks the ready flag on stop ticks 9 and 10. A design that completes the frame one tick early or late fails there. It inverts one sample at every centre position of every data bit and of the start and stop bits, and also at positions just outside the window. A design with the wrong sample window, or one that votes wrongly, reports noise where none belongs or delivers a wrong byte. Each of the three false-start patterns is followed by a clean frame. A design that publishes the held-back noise at once, loses it, or delivers the dropped frame shows the flag in the wrong frame. A start with no falling edge and a data read without a prior status read catch a receiver that ignores the edge condition or clears its flags on any data read.

// File: rtl/rx_os_pkg.sv
package rx_os_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic split3(input logic a, input logic b, input logic c);
    return !((a == b) && (b == c));
  endfunction

endpackage

// File: rtl/rx_line_sampler.sv
module rx_line_sampler (
  input  logic clk_i,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rx_i,
  output logic prev_high_o
);

  logic line_q;
  logic line_d;

  always_comb begin
    line_d = line_q;
    if (tick_i) line_d = rx_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_d;
  end

  assign prev_high_o = line_q;

endmodule

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler #(
  parameter int OSR     = 16,
  parameter int SMP_MID = 9
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rx_i,
  input  logic restart_i,
  input  logic run_i,
  output logic decide_o,
  output logic maj_o,
  output logic noisy_o
);
  import rx_os_pkg::*;

  localparam int CNT_W = $clog2(OSR + 1);
  localparam logic [CNT_W-1:0] LAST_TICK   = CNT_W'(OSR);
  localparam logic [CNT_W-1:0] FIRST_TICK  = CNT_W'(1);
  localparam logic [CNT_W-1:0] DECIDE_TICK = CNT_W'(SMP_MID + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cur;
  logic [1:0]       smp_q;

  always_comb begin
    cur = (cnt_q == LAST_TICK) ? FIRST_TICK : cnt_q + FIRST_TICK;
    cnt_d = cnt_q;
    if (restart_i)           cnt_d = FIRST_TICK;
    else if (tick_i && run_i) cnt_d = cur;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < 2; g++) begin : g_slot
    localparam logic [CNT_W-1:0] SLOT_TICK = CNT_W'(SMP_MID - 1 + g);
    logic slot_en;
    logic slot_d;
    always_comb begin
      slot_en = tick_i && run_i && (cur == SLOT_TICK);
      slot_d  = slot_en ? rx_i : smp_q[g];
    end
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) smp_q[g] <= 1'b1;
      else        smp_q[g] <= slot_d;
    end
  end

  assign decide_o = tick_i && run_i && (cur == DECIDE_TICK);
  assign maj_o    = vote3(smp_q[0], smp_q[1], rx_i);
  assign noisy_o  = split3(smp_q[0], smp_q[1], rx_i);

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm #(
  parameter int DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  rx_i,
  input  logic                  edge_ok_i,
  input  logic                  decide_i,
  input  logic                  maj_i,
  input  logic                  noisy_i,
  output logic                  restart_o,
  output logic                  run_o,
  output logic                  load_o,
  output logic [DATA_W-1:0]     load_data_o,
  output logic                  load_noise_o,
  output rx_os_pkg::rx_state_e  state_o
);
  import rx_os_pkg::*;

  localparam int BIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIDX_W-1:0] LAST_BIT = BIDX_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              fnoise_q, fnoise_d;
  logic              pend_q, pend_d;

  assign restart_o = tick_i && !rx_i && (state_q == RX_IDLE);
  assign run_o     = (state_q != RX_IDLE);

  always_comb begin
    state_d      = state_q;
    bidx_d       = bidx_q;
    shift_d      = shift_q;
    fnoise_d     = fnoise_q;
    pend_d       = pend_q;
    load_o       = 1'b0;
    load_noise_o = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (restart_o) begin
          state_d  = RX_START;
          fnoise_d = !edge_ok_i;
        end
      end
      RX_START: begin
        if (decide_i) begin
          if (maj_i) begin
            state_d = RX_IDLE;
            pend_d  = pend_q | fnoise_q | noisy_i;
          end else begin
            state_d  = RX_DATA;
            bidx_d   = '0;
            fnoise_d = fnoise_q | noisy_i;
          end
        end
      end
      RX_DATA: begin
        if (decide_i) begin
          shift_d  = {maj_i, shift_q[DATA_W-1:1]};
          fnoise_d = fnoise_q | noisy_i;
          if (bidx_q == LAST_BIT) state_d = RX_STOP;
          else                    bidx_d  = bidx_q + BIDX_W'(1);
        end
      end
      RX_STOP: begin
        if (decide_i) begin
          load_o       = 1'b1;
          load_noise_o = fnoise_q | noisy_i | pend_q;
          pend_d       = 1'b0;
          state_d      = RX_IDLE;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      bidx_q   <= '0;
      shift_q  <= '0;
      fnoise_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bidx_q   <= bidx_d;
      shift_q  <= shift_d;
      fnoise_q <= fnoise_d;
      pend_q   <= pend_d;
    end
  end

  assign load_data_o = shift_q;
  assign state_o     = state_q;

endmodule

// File: rtl/rx_status_port.sv
module rx_status_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              load_noise_i,
  input  logic              rd_stat_i,
  input  logic              rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              noise_o
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              rdy_q, rdy_d;
  logic              noise_q, noise_d;
  logic              armed_q, armed_d;
  logic              clr;

  always_comb begin
    clr     = rd_data_i && armed_q;
    data_d  = data_q;
    rdy_d   = rdy_q;
    noise_d = noise_q;
    if (load_i) begin
      data_d  = load_data_i;
      rdy_d   = 1'b1;
      noise_d = load_noise_i;
    end else if (clr) begin
      rdy_d   = 1'b0;
      noise_d = 1'b0;
    end
    armed_d = armed_q;
    if (rd_data_i)      armed_d = 1'b0;
    else if (rd_stat_i) armed_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      rdy_q   <= 1'b0;
      noise_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      rdy_q   <= rdy_d;
      noise_q <= noise_d;
      armed_q <= armed_d;
    end
  end

  assign data_o  = data_q;
  assign rdy_o   = rdy_q;
  assign noise_o = noise_q;

endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx #(
  parameter int OSR     = 16,
  parameter int SMP_MID = 9,
  parameter int DATA_W  = 8,
  parameter int STAT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              rd_stat_i,
  input  logic              rd_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_irq_o
);
  import rx_os_pkg::*;

  localparam int RDY_BIT   = 0;
  localparam int NOISE_BIT = 1;

  logic rst_meta_q, rst_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  logic              prev_high;
  logic              restart, run, decide, maj, noisy;
  logic              frm_load, frm_noise;
  logic [DATA_W-1:0] frm_data;
  rx_state_e         frm_state;
  logic              rdy, noise;

  rx_line_sampler u_line (
    .clk_i       (clk_i),
    .rst_n       (rst_n_q),
    .tick_i      (tick_i),
    .rx_i        (rx_i),
    .prev_high_o (prev_high)
  );

  rx_bit_sampler #(.OSR(OSR), .SMP_MID(SMP_MID)) u_bits (
    .clk_i     (clk_i),
    .rst_n     (rst_n_q),
    .tick_i    (tick_i),
    .rx_i      (rx_i),
    .restart_i (restart),
    .run_i     (run),
    .decide_o  (decide),
    .maj_o     (maj),
    .noisy_o   (noisy)
  );

  rx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_n        (rst_n_q),
    .tick_i       (tick_i),
    .rx_i         (rx_i),
    .edge_ok_i    (prev_high),
    .decide_i     (decide),
    .maj_i        (maj),
    .noisy_i      (noisy),
    .restart_o    (restart),
    .run_o        (run),
    .load_o       (frm_load),
    .load_data_o  (frm_data),
    .load_noise_o (frm_noise),
    .state_o      (frm_state)
  );

  rx_status_port #(.DATA_W(DATA_W)) u_stat (
    .clk_i        (clk_i),
    .rst_n        (rst_n_q),
    .load_i       (frm_load),
    .load_data_i  (frm_data),
    .load_noise_i (frm_noise),
    .rd_stat_i    (rd_stat_i),
    .rd_data_i    (rd_data_i),
    .data_o       (data_o),
    .rdy_o        (rdy),
    .noise_o      (noise)
  );

  always_comb begin
    status_o            = '0;
    status_o[RDY_BIT]   = rdy;
    status_o[NOISE_BIT] = noise;
  end

  assign rdy_irq_o = rdy;

endmodule

// File: rtl/os_uart_rx_chk.sv
module os_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_n,
  input logic                 rd_data_i,
  input logic                 load,
  input rx_os_pkg::rx_state_e state,
  input logic                 rdy,
  input logic                 noise,
  input logic [DATA_W-1:0]    data_o
);
  import rx_os_pkg::*;

  a_r5_noise_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_n)
    noise |-> rdy);

  a_r5_noise_rise_on_load: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(noise) |-> $past(load));

  a_r2_ready_rise_on_load: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rdy) |-> $past(load));

  a_r11_ready_fall_after_read: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(rdy) |-> $past(rd_data_i));

  a_r13_data_held: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(load) |-> $stable(data_o));

  a_r6_load_only_in_stop: assert property (@(posedge clk_i) disable iff (!rst_n)
    load |-> (state == RX_STOP));

endmodule

bind os_uart_rx os_uart_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i     (clk_i),
  .rst_n     (rst_n_q),
  .rd_data_i (rd_data_i),
  .load      (frm_load),
  .state     (frm_state),
  .rdy       (rdy),
  .noise     (noise),
  .data_o    (data_o)
);

// File: tb/os_uart_rx_tb_top.sv
module os_uart_rx_tb_top;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       rx;
  logic       rd_stat;
  logic       rd_data;
  logic [7:0] status;
  logic [7:0] data;
  logic       irq;

  int n_cmp;
  int n_bad;
  bit done;
  logic [7:0] last_data;

  os_uart_rx dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .rx_i      (rx),
    .rd_stat_i (rd_stat),
    .rd_data_i (rd_data),
    .status_o  (status),
    .data_o    (data),
    .rdy_irq_o (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive_tick(input logic v);
    @(negedge clk);
    rx   = v;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_stat();
    @(negedge clk); rd_stat = 1'b1;
    @(negedge clk); rd_stat = 1'b0;
  endtask

  task automatic pulse_data();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic clear_flags(input string req);
    pulse_stat();
    pulse_data();
    check(req, {24'd0, status}, 32'h0);
    check(req, {31'd0, irq}, 32'h0);
  endtask

  // gbit: 0 start, 1..8 data, 9 stop, -1 none; gtick: 1..16
  task automatic send_frame(input logic [7:0] d, input int gbit, input int gtick,
                            input logic exp_noise, input string req);
    for (int b = 0; b < 10; b++) begin
      for (int t = 1; t <= 16; t++) begin
        logic v;
        v = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : d[b-1];
        if (b == gbit && t == gtick) v = ~v;
        drive_tick(v);
        if (b == 9 && t == 9) check({req, " R2 early"}, {31'd0, status[0]}, 32'd0);
        if (b == 9 && t == 10) begin
          check({req, " status"}, {24'd0, status}, {30'd0, exp_noise, 1'b1});
          check({req, " data"}, {24'd0, data}, {24'd0, d});
          check({req, " R12 irq"}, {31'd0, irq}, 32'd1);
          last_data = d;
        end
      end
    end
  endtask

  // p[2] is tick 8, p[1] tick 9, p[0] tick 10
  task automatic false_start(input logic [2:0] p);
    for (int t = 1; t <= 16; t++) begin
      logic v;
      v = (t == 8) ? p[2] : (t == 9) ? p[1] : (t == 10) ? p[0] : (t < 8) ? 1'b0 : 1'b1;
      drive_tick(v);
    end
    check("R6 no ready, no visible noise", {24'd0, status}, 32'h0);
    check("R13 data kept after false start", {24'd0, data}, {24'd0, last_data});
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    last_data = 8'h00;
    rst_n = 1'b0; tick = 1'b0; rx = 1'b1; rd_stat = 1'b0; rd_data = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 status", {24'd0, status}, 32'h0);
    check("R1 data", {24'd0, data}, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);

    drive_tick(1'b1); drive_tick(1'b1);

    // R11: data read alone does not clear
    send_frame(8'hA5, -1, 0, 1'b0, "R2 clean");
    pulse_data();
    check("R11 data-only read keeps ready", {24'd0, status}, 32'h1);
    pulse_stat();
    pulse_data();
    check("R11 status then data clears", {24'd0, status}, 32'h0);
    pulse_data();

    // R3: every centre position of every data bit
    for (int b = 1; b <= 8; b++) begin
      for (int t = 8; t <= 10; t++) begin
        send_frame(8'h5A ^ 8'(b * 7 + t), b, t, 1'b1, "R3 centre glitch");
        clear_flags("R11 clear");
      end
    end

    // R4: outside the window
    for (int b = 1; b <= 8; b++) begin
      send_frame(8'hC3 ^ 8'(b), b, 7, 1'b0, "R4 tick7 glitch");
      clear_flags("R11 clear");
      send_frame(8'h3C ^ 8'(b), b, 11, 1'b0, "R4 tick11 glitch");
      clear_flags("R11 clear");
    end

    // R8: start bit noisy but mostly low
    for (int t = 8; t <= 10; t++) begin
      send_frame(8'h96, 0, t, 1'b1, "R8 start glitch");
      clear_flags("R11 clear");
    end

    // R10: stop bit glitch
    for (int t = 8; t <= 10; t++) begin
      send_frame(8'h69, 9, t, 1'b1, "R10 stop glitch");
      clear_flags("R11 clear");
    end

    // R6/R7: false starts then a clean frame
    begin
      logic [2:0] pats [3];
      pats[0] = 3'b011; pats[1] = 3'b101; pats[2] = 3'b110;
      for (int i = 0; i < 3; i++) begin
        false_start(pats[i]);
        send_frame(8'h3C + 8'(i), -1, 0, 1'b1, "R7 held noise");
        clear_flags("R11 clear");
        send_frame(8'h11, -1, 0, 1'b0, "R7 consumed once");
        clear_flags("R11 clear");
      end
    end

    // R9: stop bit held low, next start has no falling edge
    for (int t = 1; t <= 16; t++) drive_tick(1'b0);
    for (int b = 0; b < 8; b++) for (int t = 1; t <= 16; t++) drive_tick(8'hE7 >> b);
    for (int t = 1; t <= 10; t++) drive_tick(1'b0);
    check("R9 first frame status", {24'd0, status}, 32'h1);
    check("R9 first frame data", {24'd0, data}, 32'hE7);
    pulse_stat(); pulse_data();
    for (int t = 1; t <= 16; t++) drive_tick(1'b0);
    for (int b = 0; b < 8; b++) for (int t = 1; t <= 16; t++) drive_tick(8'h42 >> b);
    for (int t = 1; t <= 10; t++) drive_tick(1'b1);
    check("R9 no-edge start noise", {24'd0, status}, 32'h3);
    check("R9 data", {24'd0, data}, 32'h42);
    for (int t = 11; t <= 16; t++) drive_tick(1'b1);
    clear_flags("R11 clear");

    // R2/R13: all byte values
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), -1, 0, 1'b0, "R2 sweep");
      clear_flags("R11 clear");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule